// File: doc/BRIEF.md
# Register Bus Address Decoder Fabric

This block joins one master of a simple 32-bit register bus to a set of slaves. The master presents an address, write data, a write flag and a strobe, and takes back read data, an acknowledge and an error. The fabric copies the address, the write data and the write flag unchanged to every slave. It picks a slave only by passing the master strobe to that one slave and holding every other slave strobe low. The chosen slave's read data, acknowledge and error go back to the master through combinational logic, so the fabric adds no cycle to a hit.

Each slave owns a region set by a base address and a decode width. The width is the number of low address bits the slave decodes itself. A slave matches when every address bit at or above its width equals the same bit of its base. If regions overlap, the lowest-indexed slave wins. The default map has three slaves. Slave 0 sits at base 0x00000000 with width 1, covering words 0x0 and 0x1. Slave 1 sits at base 0x00000002 with width 0, a single word. Slave 2 sits at base 0x00001000 with width 4, covering 0x1000 to 0x100F. A strobed address that hits no region causes an error one cycle later.

Top module: `bus_decode_fabric`

## Requirements
- R1: With the default map, addresses 0x0 and 0x1 select slave 0, 0x2 selects slave 1, and 0x1000 to 0x100F select slave 2. Any other address, for example 0x3, 0x0FFF, 0x1010, 0x00010002 or 0x80001000, selects no slave.
- R2: Every slave's address, write data and write flag outputs equal the master's values at all times, whether or not that slave is selected. Slave i uses bits [32*i+31:32*i] of the packed buses and bit i of the flag bus.
- R3: Bit i of `s_stb` equals `m_stb` when slave i is selected and is 0 otherwise. At most one bit is ever high, and none is high while `m_stb` is low.
- R4: On a hit, `m_rdata` and `m_ack` equal the selected slave's read data and acknowledge in the same cycle, and `m_err` carries that slave's error. The responses of unselected slaves have no effect on the master outputs.
- R5: If the strobe is high at a clock edge and the address selects no slave, then after that edge `m_err` is 1 and `m_ack` is 0. While no slave is selected, `m_rdata` is 0.
- R6: While reset (active high, synchronous) is high, a strobed unmapped address produces no error, and after a reset edge `m_err` is 0 until a slave reports an error.
- R7: When several regions match, the lowest-indexed slave alone receives the strobe. For example, with slave 0 at 0x1000 of width 4 and slave 1 at 0x1004 of width 0, address 0x1004 strobes only slave 0.
- R8: A miss error lasts only while the strobed miss continues. After an edge at which the strobe is low, `m_err` is 0 unless the selected slave reports an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | 32 | Master address |
| m_wdata | input | 32 | Master write data |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write flag |
| m_rdata | output | 32 | Read data returned to the master |
| m_ack | output | 1 | Acknowledge returned to the master |
| m_err | output | 1 | Error returned to the master |
| s_addr | output | 32*NSLV | Address broadcast, one slot per slave |
| s_wdata | output | 32*NSLV | Write data broadcast, one slot per slave |
| s_stb | output | NSLV | Per-slave strobe |
| s_we | output | NSLV | Per-slave write flag |
| s_rdata | input | 32*NSLV | Per-slave read data |
| s_ack | input | NSLV | Per-slave acknowledge |
| s_err | input | NSLV | Per-slave error |

## Verification
The bench probes the edges of each region. It drives the first and last word of slave 2, the word just past slave 0 and the word before slave 2. It also drives addresses that differ from a base only in high bits. A mask that is off by one bit, or a comparison that ignores the upper half, would strobe a slave at these addresses when it should not. Unselected slaves are given a raised acknowledge or error, and a fan-in that ORs all responses instead of multiplexing them would pass these to the master. A second instance with overlapping regions shows whether priority goes to the lowest index rather than the highest. The miss error is checked one edge after the strobe, again after the strobe drops, and under reset, which catches an error that is combinational, sticky or not reset.

// File: rtl/bus_decode_fabric.sv
module bus_decode_fabric #(
  parameter int NSLV = 3,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [NSLV*AW-1:0] BASES  = {32'h0000_1000, 32'h0000_0002, 32'h0000_0000},
  parameter logic [NSLV*8-1:0]  WIDTHS = {8'd4, 8'd0, 8'd1}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      m_addr,
  input  logic [DW-1:0]      m_wdata,
  input  logic               m_stb,
  input  logic               m_we,
  output logic [DW-1:0]      m_rdata,
  output logic               m_ack,
  output logic               m_err,
  output logic [NSLV*AW-1:0] s_addr,
  output logic [NSLV*DW-1:0] s_wdata,
  output logic [NSLV-1:0]    s_stb,
  output logic [NSLV-1:0]    s_we,
  input  logic [NSLV*DW-1:0] s_rdata,
  input  logic [NSLV-1:0]    s_ack,
  input  logic [NSLV-1:0]    s_err
);
  localparam int SW = (NSLV > 1) ? $clog2(NSLV) : 1;

  logic [NSLV-1:0] match;
  logic [SW-1:0]   sel;
  logic            hit;
  logic            miss_q;

  for (genvar i = 0; i < NSLV; i++) begin : g_slot
    localparam logic [AW-1:0] MASK = {AW{1'b1}} << WIDTHS[i*8 +: 8];
    assign match[i] = ((m_addr ^ BASES[i*AW +: AW]) & MASK) == '0;
    assign s_addr[i*AW +: AW]  = m_addr;
    assign s_wdata[i*DW +: DW] = m_wdata;
    assign s_we[i]  = m_we;
    assign s_stb[i] = m_stb & hit & (sel == SW'(i));
  end

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = NSLV - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = SW'(i);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miss_q <= 1'b0;
    else     miss_q <= m_stb & ~hit;
  end

  assign m_rdata = hit ? s_rdata[int'(sel)*DW +: DW] : '0;
  assign m_ack   = hit & s_ack[sel] & ~miss_q;
  assign m_err   = miss_q | (hit & s_err[sel]);
endmodule

// File: rtl/bus_decode_fabric_chk.sv
module bus_decode_fabric_chk #(
  parameter int NSLV = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      m_addr,
  input logic [DW-1:0]      m_wdata,
  input logic               m_stb,
  input logic               m_we,
  input logic               m_ack,
  input logic               m_err,
  input logic [NSLV*AW-1:0] s_addr,
  input logic [NSLV*DW-1:0] s_wdata,
  input logic [NSLV-1:0]    s_stb,
  input logic [NSLV-1:0]    s_we,
  input logic [NSLV-1:0]    s_ack
);
  for (genvar g = 0; g < NSLV; g++) begin : g_bc
    p_broadcast_r2: assert property (@(posedge clk) disable iff (rst)
      s_addr[g*AW +: AW] == m_addr && s_wdata[g*DW +: DW] == m_wdata && s_we[g] == m_we);
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(s_stb));

  p_strobe_needs_master_r3: assert property (@(posedge clk) disable iff (rst)
    (s_stb != '0) |-> m_stb);

  p_ack_from_slave_r4: assert property (@(posedge clk) disable iff (rst)
    (s_ack == '0) |-> !m_ack);

  p_miss_err_r5: assert property (@(posedge clk) disable iff (rst)
    (m_stb && s_stb == '0) |=> (m_err && !m_ack));

  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> !m_err || $countones(s_stb) == 1);
endmodule

bind bus_decode_fabric bus_decode_fabric_chk #(.NSLV(NSLV), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_stb(m_stb), .m_we(m_we),
  .m_ack(m_ack), .m_err(m_err), .s_addr(s_addr), .s_wdata(s_wdata), .s_stb(s_stb),
  .s_we(s_we), .s_ack(s_ack)
);

// File: tb/bus_decode_fabric_test.sv
module bus_decode_fabric_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_stb = 1'b0, m_we = 1'b0;
  logic [31:0] m_rdata;
  logic        m_ack, m_err;
  logic [95:0] s_addr, s_wdata, s_rdata;
  logic [2:0]  s_stb, s_we, s_ack, s_err;
  logic [2:0]  ack_force = '0, err_force = '0;

  assign s_rdata = {32'hA500_0002, 32'hA500_0001, 32'hA500_0000};
  assign s_ack   = s_stb | ack_force;
  assign s_err   = err_force;

  bus_decode_fabric uut (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_stb(m_stb), .m_we(m_we),
    .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_stb(s_stb), .s_we(s_we), .s_rdata(s_rdata), .s_ack(s_ack), .s_err(s_err));

  logic [31:0] p_rdata;
  logic        p_ack, p_err;
  logic [63:0] p_saddr, p_swdata;
  logic [1:0]  p_stb, p_we;

  bus_decode_fabric #(.NSLV(2), .BASES({32'h0000_1004, 32'h0000_1000}), .WIDTHS({8'd0, 8'd4})) uut2 (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_stb(m_stb), .m_we(m_we),
    .m_rdata(p_rdata), .m_ack(p_ack), .m_err(p_err), .s_addr(p_saddr), .s_wdata(p_swdata),
    .s_stb(p_stb), .s_we(p_we), .s_rdata({32'hB000_0001, 32'hB000_0000}), .s_ack(p_stb),
    .s_err(2'b00));

  int checks = 0, errors = 0;

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 2'd0}, {32'h0000_0001, 1'b1, 2'd0},
    {32'h0000_0002, 1'b1, 2'd1}, {32'h0000_0003, 1'b0, 2'd0},
    {32'h0000_1000, 1'b1, 2'd2}, {32'h0000_100F, 1'b1, 2'd2},
    {32'h0000_1010, 1'b0, 2'd0}, {32'h0000_0FFF, 1'b0, 2'd0},
    {32'h8000_0000, 1'b0, 2'd0}, {32'h8000_1000, 1'b0, 2'd0},
    {32'h0001_0002, 1'b0, 2'd0}};

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    m_addr = 32'h3; m_stb = 1'b1;
    @(posedge clk); #2;
    chk("R6 miss under reset", {95'b0, m_err}, 96'd0);
    chk("R6 ack under reset", {95'b0, m_ack}, 96'd0);
    @(negedge clk); m_stb = 1'b0; rst = 1'b0;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      logic hit;
      logic [1:0] sel;
      @(negedge clk);
      hit = VEC[i][2]; sel = VEC[i][1:0];
      m_addr = VEC[i][34:3]; m_wdata = 32'h1111_1111 * (i + 1); m_we = i[0]; m_stb = 1'b1;
      #2;
      chk("R1/R3 strobe select", {93'b0, s_stb}, hit ? 96'(3'b1 << sel) : 96'd0);
      chk("R2 broadcast", {s_addr[95:64] ^ m_addr, s_wdata[31:0] ^ m_wdata, 29'b0, s_we ^ {3{m_we}}}, 96'd0);
      chk("R4 read data", {64'b0, m_rdata}, hit ? {64'b0, 32'hA500_0000 + 32'(sel)} : 96'd0);
      chk("R4 ack", {95'b0, m_ack}, {95'b0, hit});
      @(posedge clk); #2;
      chk("R5 err after edge", {94'b0, m_err, m_ack}, {94'b0, !hit, hit});
      @(negedge clk); m_stb = 1'b0;
      @(posedge clk); #2;
      chk("R8 err clears", {95'b0, m_err}, 96'd0);
    end

    @(negedge clk);
    m_addr = 32'h1004; m_stb = 1'b1; ack_force = 3'b001; err_force = 3'b010;
    #2;
    chk("R4 other slave ack and err ignored", {93'b0, m_ack, m_err, 1'b0}, {93'b0, 1'b1, 1'b0, 1'b0});
    m_stb = 1'b0; err_force = 3'b100; ack_force = 3'b000;
    #1;
    chk("R4 selected slave err", {95'b0, m_err}, 96'd1);
    m_addr = 32'h2; ack_force = 3'b001; err_force = 3'b001;
    #1;
    chk("R4 unselected ack/err ignored", {94'b0, m_ack, m_err}, 96'd0);
    ack_force = '0; err_force = '0;

    @(negedge clk);
    m_addr = 32'h1004; m_stb = 1'b1;
    #2;
    chk("R7 overlap lowest wins", {94'b0, p_stb}, 96'd1);
    chk("R7 overlap data", {64'b0, p_rdata}, {64'b0, 32'hB000_0000});
    m_addr = 32'h1005;
    #1;
    chk("R7 inside low slave only", {94'b0, p_stb}, 96'd1);

    @(negedge clk);
    m_addr = 32'h5555_0000; m_stb = 1'b1;
    @(posedge clk); #2;
    chk("R5 miss raises err", {95'b0, m_err}, 96'd1);
    chk("R5 miss rdata zero", {64'b0, m_rdata}, 96'd0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk("R6 reset clears err", {95'b0, m_err}, 96'd0);
    @(negedge clk); rst = 1'b0; m_stb = 1'b0;
    @(posedge clk); #2;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule